// File: doc/BRIEF.md
# Rotating Framebuffer Scanout Address Generator

This block produces the stream of byte addresses a display fetch engine uses to read a 16-bit-per-pixel framebuffer, one panel line at a time. A frame is 329 lines of 240 reads each. The first nine lines are blanking lines, and the remaining 320 carry the picture. The sequence repeats frame after frame with no outside help.

Two walk orders are offered. Portrait order reads the buffer as one linear raster. Landscape order reads it by column, so that an image stored as 320 pixels wide by 240 tall appears on the 240x320 panel turned a quarter turn. In landscape order, each visible line starts two bytes lower in memory than the line before it, and the reads within a line are one stored row (640 bytes) apart. Each blanking line starts at the buffer origin.

Addresses leave on a valid/ready stream. `addr_valid` stays high from the first cycle after reset is released, for as long as reset stays low. The consumer sets `addr_ready` to take the offered address. When `addr_valid` and `addr_ready` are high on the same rising edge, that address is consumed and the next one is offered in the following cycle. While `addr_ready` is low, the address and all of its markers hold still. The base address and the mode select are sampled only when a frame begins, so they may change at any time.

Top module: `scan_addr_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `addr_valid` is 0. In the next cycle `addr_valid` is 1, and the first address of a frame is offered using the `base_addr` and `landscape_sel` values present in the cycle after release.
- R2: The offered address and its markers change only after a rising edge where `addr_valid` and `addr_ready` are both 1. While `addr_ready` is 0 they hold their values.
- R3: A frame is 329 lines of 240 accepted addresses each. After the last address of line 328 is accepted, the next address offered is the first address of line 0, with `frame_start` set and the address equal to the frame's base.
- R4: When `landscape_sel` = 0 (portrait), the address for line L and pixel P is base + (240·L + P)·2.
- R5: When `landscape_sel` = 1 (landscape), the address for blanking line L (0 to 8) and pixel P is base + 640·P.
- R6: When `landscape_sel` = 1, the address for visible line L (9 to 328) and pixel P is base + (328 − L)·2 + 640·P.
- R7: `blank` is 1 for every address of lines 0 to 8 and 0 for every address of lines 9 to 328.
- R8: `line_start` is 1 exactly on pixel 0 of every line. `frame_start` is 1 exactly on pixel 0 of line 0.
- R9: `base_addr` and `landscape_sel` are sampled only when the first address of a frame is produced. A change in the middle of a frame has no effect on the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_addr | input | 32 | Byte address of the framebuffer origin, sampled at frame start |
| landscape_sel | input | 1 | 0 selects portrait order, 1 selects landscape order; sampled at frame start |
| addr_valid | output | 1 | An address is on offer |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr | output | 32 | Byte address of the offered pixel read |
| line_start | output | 1 | Offered address is the first of its line |
| frame_start | output | 1 | Offered address is the first of the frame |
| blank | output | 1 | Offered address belongs to a blanking line |

## Verification
The most delicate cycle is the acceptance of the last address of a frame. In that one cycle the line counter and pixel counter both wrap, and a new mode and base are sampled. The bench sets up this overlap by changing both `landscape_sel` and `base_addr` early in a portrait frame and then streaming to its final read. It then judges two things: the rest of the old frame must still follow the old base in portrait order, and the very next offered address must be the new base with `frame_start` set, followed by landscape strides. The bench also holds `addr_ready` low just after that wrap, to show that back-pressure freezes the landscape stream in place.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic {
    MODE_PORTRAIT  = 1'b0,
    MODE_LANDSCAPE = 1'b1
  } scan_mode_e;

endpackage

// File: rtl/scan_wrap_ctr.sv
module scan_wrap_ctr #(
  parameter int MODULUS = 240,
  localparam int CW = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_last
);

  localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end

  AST_CTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R3

  AST_CTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && at_last && !clr) |=> (cnt == '0)); // R3

endmodule

// File: rtl/scan_position.sv
module scan_position #(
  parameter int LINE_PIX    = 240,
  parameter int TOTAL_LINES = 329,
  localparam int PIX_W  = $clog2(LINE_PIX),
  localparam int LINE_W = $clog2(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line,
  output logic              pix_last,
  output logic              frame_last
);

  logic line_last;

  scan_wrap_ctr #(.MODULUS(LINE_PIX)) u_pix_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .inc     (step),
    .cnt     (pix),
    .at_last (pix_last)
  );

  scan_wrap_ctr #(.MODULUS(TOTAL_LINES)) u_line_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .inc     (step && pix_last),
    .cnt     (line),
    .at_last (line_last)
  );

  assign frame_last = pix_last && line_last;

  AST_LINE_ADVANCES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pix_last && !line_last && !clr) |=> (line == $past(line) + 1'b1)); // R3

  AST_LINE_HOLDS_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_last && !clr) |=> $stable(line)); // R3

endmodule

// File: rtl/scan_addr_calc.sv
module scan_addr_calc
  import scan_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PIX_BYTES   = 2,
  parameter int VIS_LINES   = 320,
  parameter int BLANK_LINES = 9,
  localparam int TOTAL_LINES = VIS_LINES + BLANK_LINES,
  localparam int LINE_W      = $clog2(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_base,
  input  logic              step,
  input  logic              pix_last,
  input  logic [LINE_W-1:0] line,
  input  logic [ADDR_W-1:0] base_r,
  input  scan_mode_e        mode,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] PIX_STEP   = ADDR_W'(PIX_BYTES);
  localparam logic [ADDR_W-1:0] COL_STRIDE = ADDR_W'(VIS_LINES * PIX_BYTES);
  localparam logic [ADDR_W-1:0] LAST_IDX   = ADDR_W'(TOTAL_LINES - 1);
  localparam logic [ADDR_W-1:0] BLANK_END  = ADDR_W'(BLANK_LINES);

  logic [ADDR_W-1:0] next_line_idx;
  logic [ADDR_W-1:0] land_line_origin;
  logic [ADDR_W-1:0] inline_stride;
  logic [ADDR_W-1:0] line_origin;
  logic [ADDR_W-1:0] addr_nxt;

  assign next_line_idx = ADDR_W'(line) + 1'b1;

  always_comb begin
    if (next_line_idx < BLANK_END) begin
      land_line_origin = base_r;
    end else begin
      land_line_origin = base_r + (LAST_IDX - next_line_idx) * PIX_STEP;
    end
  end

  assign inline_stride = (mode == MODE_LANDSCAPE) ? COL_STRIDE : PIX_STEP;
  assign line_origin   = (mode == MODE_LANDSCAPE) ? land_line_origin : addr + PIX_STEP;

  always_comb begin
    addr_nxt = addr;
    if (load) begin
      addr_nxt = load_base;
    end else if (step) begin
      addr_nxt = pix_last ? line_origin : addr + inline_stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else begin
      addr <= addr_nxt;
    end
  end

  AST_PORTRAIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode == MODE_PORTRAIT) |=> (addr == $past(addr) + PIX_STEP)); // R4

  AST_LAND_COLUMN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !pix_last && mode == MODE_LANDSCAPE)
      |=> (addr == $past(addr) + COL_STRIDE)); // R5

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(addr)); // R2

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PIX_BYTES   = 2,
  parameter int LINE_PIX    = 240,
  parameter int VIS_LINES   = 320,
  parameter int BLANK_LINES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              landscape_sel,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              line_start,
  output logic              frame_start,
  output logic              blank
);

  localparam int TOTAL_LINES = VIS_LINES + BLANK_LINES;
  localparam int PIX_W       = $clog2(LINE_PIX);
  localparam int LINE_W      = $clog2(TOTAL_LINES);
  localparam logic [LINE_W-1:0] BLANK_END = LINE_W'(BLANK_LINES);

  logic              running;
  logic              accept;
  logic              load;
  logic [ADDR_W-1:0] base_r;
  scan_mode_e        mode_r;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  logic              pix_last;
  logic              frame_last;

  assign accept = running && addr_ready;
  assign load   = !running || (accept && frame_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      base_r  <= '0;
      mode_r  <= MODE_PORTRAIT;
    end else begin
      running <= 1'b1;
      if (load) begin
        base_r <= base_addr;
        mode_r <= scan_mode_e'(landscape_sel);
      end
    end
  end

  scan_position #(
    .LINE_PIX    (LINE_PIX),
    .TOTAL_LINES (TOTAL_LINES)
  ) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (load),
    .step       (accept),
    .pix        (pix),
    .line       (line),
    .pix_last   (pix_last),
    .frame_last (frame_last)
  );

  scan_addr_calc #(
    .ADDR_W      (ADDR_W),
    .PIX_BYTES   (PIX_BYTES),
    .VIS_LINES   (VIS_LINES),
    .BLANK_LINES (BLANK_LINES)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_base (base_addr),
    .step      (accept),
    .pix_last  (pix_last),
    .line      (line),
    .base_r    (base_r),
    .mode      (mode_r),
    .addr      (addr)
  );

  assign addr_valid  = running;
  assign line_start  = running && (pix == '0);
  assign frame_start = running && (pix == '0) && (line == '0);
  assign blank       = running && (line < BLANK_END);

  AST_FRAME_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (addr == base_r)); // R3

  AST_FRAME_IS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_start && blank)); // R8

  AST_SETTINGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(accept && frame_last)) |=> ($stable(mode_r) && $stable(base_r))); // R9

  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready)
      |=> ($stable(addr) && $stable(line_start) && $stable(blank))); // R2

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> addr_valid); // R1

endmodule

// File: tb/tb_scan_addr_gen.sv
module tb_scan_addr_gen;

  localparam int FRAME_READS = 329 * 240;
  localparam logic [31:0] BASE_A = 32'h0004_0000;
  localparam logic [31:0] BASE_B = 32'h0020_0000;

  typedef struct packed {
    logic        frm;
    logic [8:0]  ln;
    logic [7:0]  px;
    logic        chg;
    logic        eb;
    logic        els;
    logic        efs;
    logic        bsel;
    logic [31:0] off;
  } vec_t;

  // frame 0 portrait on BASE_A; mode and base are changed mid-frame (chg),
  // frame 1 must then be landscape on BASE_B
  localparam vec_t VECS [16] = '{
    '{1'b0, 9'd0,   8'd0,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0},
    '{1'b0, 9'd0,   8'd239, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'd478},
    '{1'b0, 9'd1,   8'd0,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'd480},
    '{1'b0, 9'd8,   8'd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'd3840},
    '{1'b0, 9'd9,   8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd4320},
    '{1'b0, 9'd200, 8'd17,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd96034},
    '{1'b0, 9'd328, 8'd239, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd157918},
    '{1'b1, 9'd0,   8'd0,   1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'd0},
    '{1'b1, 9'd0,   8'd1,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'd640},
    '{1'b1, 9'd8,   8'd239, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'd152960},
    '{1'b1, 9'd9,   8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'd638},
    '{1'b1, 9'd9,   8'd1,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd1278},
    '{1'b1, 9'd10,  8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'd636},
    '{1'b1, 9'd100, 8'd5,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd3656},
    '{1'b1, 9'd328, 8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'd0},
    '{1'b1, 9'd328, 8'd239, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd152960}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_addr = BASE_A;
  logic        landscape_sel = 1'b0;
  logic        addr_valid;
  logic        addr_ready = 1'b0;
  logic [31:0] addr;
  logic        line_start;
  logic        frame_start;
  logic        blank;

  int n_tests = 0;
  int n_fail  = 0;
  int abs_pos = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  scan_addr_gen dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_addr     (base_addr),
    .landscape_sel (landscape_sel),
    .addr_valid    (addr_valid),
    .addr_ready    (addr_ready),
    .addr          (addr),
    .line_start    (line_start),
    .frame_start   (frame_start),
    .blank         (blank)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic advance(int n);
    if (n > 0) begin
      addr_ready = 1'b1;
      repeat (n) @(negedge clk);
      addr_ready = 1'b0;
      abs_pos += n;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(addr_valid), 32'd0);
    rst_n = 1'b1;
    check("R1 valid first cycle", 32'(addr_valid), 32'd0);
    @(negedge clk);
    check("R1 valid after load", 32'(addr_valid), 32'd1);

    // table walk across a portrait frame into a landscape frame
    foreach (VECS[i]) begin
      automatic int target = int'(VECS[i].frm) * FRAME_READS
                           + int'(VECS[i].ln) * 240 + int'(VECS[i].px);
      automatic logic [31:0] b = VECS[i].bsel ? BASE_B : BASE_A;
      automatic string tag = (VECS[i].frm == 1'b0) ? ((i > 2) ? "R4/R9" : "R4")
                           : ((VECS[i].ln < 9) ? "R5" : "R6");
      advance(target - abs_pos);
      check(tag, addr, b + VECS[i].off);
      check("R7 blank", 32'(blank), 32'(VECS[i].eb));
      check("R8 line_start", 32'(line_start), 32'(VECS[i].els));
      check((i == 7) ? "R3 frame_start" : "R8 frame_start",
            32'(frame_start), 32'(VECS[i].efs));
      if (VECS[i].chg) begin
        landscape_sel = 1'b1;
        base_addr     = BASE_B;
      end
    end

    // second wrap: R3 repeats with no host action
    advance(1);
    check("R3 wrap addr", addr, BASE_B);
    check("R3 wrap frame_start", 32'(frame_start), 32'd1);
    advance(1);
    check("R5 after wrap", addr, BASE_B + 32'd640);

    // back-pressure: R2
    repeat (3) @(negedge clk);
    check("R2 stall addr", addr, BASE_B + 32'd640);
    check("R2 stall valid", 32'(addr_valid), 32'd1);
    check("R2 stall line_start", 32'(line_start), 32'd0);

    // reset mid-run, restart in portrait: R1
    rst_n = 1'b0;
    landscape_sel = 1'b0;
    base_addr = BASE_A;
    @(negedge clk);
    check("R1 valid in second reset", 32'(addr_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 restart addr", addr, BASE_A);
    check("R1 restart frame_start", 32'(frame_start), 32'd1);
    advance(1);
    check("R4 restart step", addr, BASE_A + 32'd2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule